// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns the virtual address of a data load or store into a physical address. A 64-entry, fully associative table of page mappings holds the translations. Before any table search, fixed rules for address windows and a translation-enable input decide the outcome. Two windows always bypass the table. When translation is off, every other address is folded to its low 29 bits. When the table is searched, the block returns the physical address and a permission set. If the access is not allowed, it returns a 12-bit fault code instead. The fault codes cover a miss, a protection violation, a first write to a clean page, an ambiguous (multiple) hit and a user-mode address error.

A 6-bit replacement index steps on every table search. It wraps at a boundary that software programs, or at the end of the table when the boundary is zero. A load port writes one complete entry into the slot that the index points to, which gives software round-robin refill. For most faults the block records the faulting address and its page-number bits, so a refill handler can use them directly. Each response appears one clock after its request.

Top module: `data_xlate_unit`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. After reset, `rsp_valid`, `rep_idx`, `flt_addr` and `flt_vpn` are all zero.
- R2: Fixed windows bypass the table and grant permission 3'b111, where bit 0 is read, bit 1 is write and bit 2 is execute. Addresses 0x80000000 to 0xBFFFFFFF have their top three bits cleared. Addresses from 0xE0000000 upward pass through unchanged.
- R3: A user-mode access (`req_priv` low) to a fixed window faults, unless the address lies in 0xE0000000 to 0xE3FFFFFF. The fault code is 0x0E0 for a load and 0x100 for a store.
- R4: With `cfg_xlate_en` low, any address outside the fixed windows maps to its low 29 bits with permission 3'b111.
- R5: A valid entry matches when the address lies inside its page. Size code 0 means 1 KB, 1 means 4 KB, 2 means 64 KB and 3 means 1 MB. The page base is the page number shifted left by 10 with the bits below the page size cleared. The physical address is the frame number shifted left by 10, with the bits below the page size taken from the virtual address.
- R6: A search with no matching valid entry faults with 0x040 for a load and 0x060 for a store. Every fault reports physical address 0 and permission 0.
- R7: In user mode, a hit on an entry whose protection bit 1 is clear faults with 0x0A0 for a load and 0x0C0 for a store.
- R8: If R7 does not apply, a store hitting an entry whose protection bit 0 is clear faults with 0x0C0. Otherwise, a store hitting an entry whose dirty bit is clear faults with 0x080.
- R9: A permitted hit grants read, never execute, and grants write only when protection bit 0 and the dirty bit are both set.
- R10: More than one matching valid entry faults with 0x140 and leaves `flt_addr` and `flt_vpn` unchanged.
- R11: Every other fault loads `flt_addr` with the request address and `flt_vpn` with its bits 31:10.
- R12: `rep_idx` advances by one on each table search, and only then. It returns to 0 when the new value would exceed a non-zero `cfg_wrap_bound`, or would exceed 63.
- R13: A pulse on `ld_valid` writes the supplied entry into slot `rep_idx` without moving `rep_idx`. The entry is visible to the next request. An entry loaded with its valid bit clear never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xlate_en | input | 1 | Translation enable |
| cfg_wrap_bound | input | 6 | Replacement index wrap boundary, 0 means full table |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_priv | input | 1 | 1 for privileged mode, 0 for user mode |
| ld_valid | input | 1 | Write entry at `rep_idx` |
| ld_entry_ok | input | 1 | Valid bit of the loaded entry |
| ld_vpn | input | 22 | Page number (virtual address bits 31:10) |
| ld_ppn | input | 19 | Frame number (physical address bits 28:10) |
| ld_size | input | 2 | Page size code |
| ld_prot | input | 2 | Protection bits: bit 1 user access, bit 0 writable |
| ld_dirty | input | 1 | Dirty bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 12 | Fault code, 0 when no fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permission set {exec, write, read} |
| rep_idx | output | 6 | Replacement index |
| flt_addr | output | 32 | Last recorded fault address |
| flt_vpn | output | 22 | Page number of last recorded fault |

## Verification
The assertions assume that a load and a request never arrive in the same cycle, and that the configuration inputs change only while no request is in flight. The stimulus issues loads and requests in separate, single-cycle pulses, and changes configuration only between them. The stimulus reaches every fault code, all four page sizes, both index wrap rules and an overlap of two entries. A behavioural model in the bench predicts every response, the index and the fault record, and compares them against the outputs.

// File: rtl/xlate_pkg.sv
// Shared types and constants for the data address translation unit.
// Assumes 32-bit virtual and physical addresses with a 1 KB minimum page.
package xlate_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 10;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int PPN_W  = 29 - PG_LSB;
    localparam int CODE_W = 12;

    localparam logic [CODE_W-1:0] FC_NONE      = 12'h000;
    localparam logic [CODE_W-1:0] FC_MISS_RD   = 12'h040;
    localparam logic [CODE_W-1:0] FC_MISS_WR   = 12'h060;
    localparam logic [CODE_W-1:0] FC_FIRST_WR  = 12'h080;
    localparam logic [CODE_W-1:0] FC_PROT_RD   = 12'h0A0;
    localparam logic [CODE_W-1:0] FC_PROT_WR   = 12'h0C0;
    localparam logic [CODE_W-1:0] FC_ADDR_RD   = 12'h0E0;
    localparam logic [CODE_W-1:0] FC_ADDR_WR   = 12'h100;
    localparam logic [CODE_W-1:0] FC_MULTI     = 12'h140;

    typedef struct packed {
        logic             ok;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       size;
        logic [1:0]       prot;
        logic             dirty;
    } map_entry_t;

    // Low-bit mask covering the in-page offset for a size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    page_mask = 32'h0000_03FF;
            2'd1:    page_mask = 32'h0000_0FFF;
            2'd2:    page_mask = 32'h0000_FFFF;
            default: page_mask = 32'h000F_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/xlate_window_decode.sv
// Classifies a virtual address against the fixed windows and the enable.
// Purely combinational; assumes 32-bit addresses.
module xlate_window_decode
    import xlate_pkg::*;
(
    input  logic [VA_W-1:0] addr,
    input  logic            priv,
    input  logic            xlate_en,
    output logic            win_err,
    output logic            need_search,
    output logic [VA_W-1:0] direct_pa
);
    logic in_low_fixed;
    logic in_top_fixed;
    logic in_user_hole;

    // Decode window membership from the upper address bits.
    always_comb begin
        in_low_fixed = (addr[31:30] == 2'b10);
        in_top_fixed = (addr[31:29] == 3'b111);
        in_user_hole = (addr[31:26] == 6'b111000);
        win_err      = (in_low_fixed || in_top_fixed) && !priv && !in_user_hole;
        need_search  = xlate_en && !in_low_fixed && !in_top_fixed;
        if (in_top_fixed) direct_pa = addr;
        else              direct_pa = {3'b000, addr[28:0]};
    end
endmodule

// File: rtl/xlate_repl_counter.sv
// Round-robin replacement index with a programmable wrap boundary.
// Assumes the boundary is held stable while searches are issued.
module xlate_repl_counter #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] inc;
    logic           wrap;

    // Form the incremented value and the wrap decision.
    always_comb begin
        inc  = {1'b0, idx} + 1'b1;
        wrap = inc[IDX_W] || ((bound != '0) && (inc > {1'b0, bound}));
    end

    // Advance the index on each search.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (step) idx <= wrap ? '0 : inc[IDX_W-1:0];
    end

    assert_idx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx));
    assert_idx_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx == '0) || (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/xlate_map_array.sv
// Fully associative store of page mappings with parallel match.
// Reports any-hit, multiple-hit and the OR of all hit entries.
// Assumes the write port and lookups are never used in the same cycle.
module xlate_map_array
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  map_entry_t       wr_data,
    input  logic [VA_W-1:0]  look_addr,
    output logic             hit_any,
    output logic             hit_multi,
    output map_entry_t       hit_data
);
    map_entry_t           slots_q [ENTRIES];
    logic [ENTRIES-1:0]   hits;

    // Per-slot storage and match logic.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] msk;

        // Slot valid bit, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                           slots_q[g].ok <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(g)) slots_q[g].ok <= wr_data.ok;
        end

        // Slot mapping fields, written with the valid bit.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                slots_q[g].vpn   <= wr_data.vpn;
                slots_q[g].ppn   <= wr_data.ppn;
                slots_q[g].size  <= wr_data.size;
                slots_q[g].prot  <= wr_data.prot;
                slots_q[g].dirty <= wr_data.dirty;
            end
        end

        // Page base compare under the slot's size mask.
        always_comb begin
            msk     = page_mask(slots_q[g].size);
            base    = {slots_q[g].vpn, {PG_LSB{1'b0}}} & ~msk;
            hits[g] = slots_q[g].ok && ((look_addr & ~msk) == base);
        end
    end

    // Merge hit results into a single entry and a multiplicity flag.
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hits[i]) hit_data = map_entry_t'(hit_data | slots_q[i]);
        end
        hit_any   = |hits;
        hit_multi = |(hits & (hits - 1'b1));
    end

    assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && !hit_multi) |-> ($countones(hits) == 1));
    assert_load_visible_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slots_q[$past(wr_idx)].ok == $past(wr_data.ok)));
endmodule

// File: rtl/data_xlate_unit.sv
// Data address translation: fixed-window bypass, table search, protection
// checks, fault recording and a replacement index for refill.
// Assumes load and request strobes never coincide and configuration only
// changes while no request is pending.
module data_xlate_unit
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_xlate_en,
    input  logic [IDX_W-1:0]  cfg_wrap_bound,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_store,
    input  logic              req_priv,
    input  logic              ld_valid,
    input  logic              ld_entry_ok,
    input  logic [21:0]       ld_vpn,
    input  logic [18:0]       ld_ppn,
    input  logic [1:0]        ld_size,
    input  logic [1:0]        ld_prot,
    input  logic              ld_dirty,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic [IDX_W-1:0]  rep_idx,
    output logic [31:0]       flt_addr,
    output logic [21:0]       flt_vpn
);
    logic              win_err;
    logic              need_search;
    logic [VA_W-1:0]   direct_pa;
    logic              hit_any;
    logic              hit_multi;
    map_entry_t        hit_e;
    map_entry_t        ld_e;
    logic [VA_W-1:0]   hmask;

    logic              n_fault;
    logic [CODE_W-1:0] n_code;
    logic [VA_W-1:0]   n_pa;
    logic [2:0]        n_perm;

    xlate_window_decode u_win (
        .addr        (req_addr),
        .priv        (req_priv),
        .xlate_en    (cfg_xlate_en),
        .win_err     (win_err),
        .need_search (need_search),
        .direct_pa   (direct_pa)
    );

    xlate_repl_counter #(.IDX_W(IDX_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid && need_search),
        .bound (cfg_wrap_bound),
        .idx   (rep_idx)
    );

    // Pack the load port into an entry.
    always_comb begin
        ld_e = '{ok: ld_entry_ok, vpn: ld_vpn, ppn: ld_ppn,
                 size: ld_size, prot: ld_prot, dirty: ld_dirty};
    end

    xlate_map_array #(.ENTRIES(ENTRIES)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_valid),
        .wr_idx    (rep_idx),
        .wr_data   (ld_e),
        .look_addr (req_addr),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_data  (hit_e)
    );

    // Select the outcome in priority order.
    always_comb begin
        n_fault = 1'b1;
        n_code  = FC_NONE;
        n_pa    = '0;
        n_perm  = 3'b000;
        hmask   = page_mask(hit_e.size);
        if (win_err) begin
            n_code = req_store ? FC_ADDR_WR : FC_ADDR_RD;
        end else if (!need_search) begin
            n_fault = 1'b0;
            n_pa    = direct_pa;
            n_perm  = 3'b111;
        end else if (hit_multi) begin
            n_code = FC_MULTI;
        end else if (!hit_any) begin
            n_code = req_store ? FC_MISS_WR : FC_MISS_RD;
        end else if (!req_priv && !hit_e.prot[1]) begin
            n_code = req_store ? FC_PROT_WR : FC_PROT_RD;
        end else if (req_store && !hit_e.prot[0]) begin
            n_code = FC_PROT_WR;
        end else if (req_store && !hit_e.dirty) begin
            n_code = FC_FIRST_WR;
        end else begin
            n_fault = 1'b0;
            n_pa    = ({3'b000, hit_e.ppn, {PG_LSB{1'b0}}} & ~hmask)
                      | (req_addr & hmask);
            n_perm  = {1'b0, hit_e.prot[0] & hit_e.dirty, 1'b1};
        end
    end

    // Register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= n_fault;
                rsp_code  <= n_code;
                rsp_paddr <= n_pa;
                rsp_perm  <= n_perm;
            end
        end
    end

    // Record the faulting address for all faults except multiple hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_addr <= '0;
            flt_vpn  <= '0;
        end else if (req_valid && n_fault && n_code != FC_MULTI) begin
            flt_addr <= req_addr;
            flt_vpn  <= req_addr[31:PG_LSB];
        end
    end

    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fault_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000 && rsp_paddr == '0));
    assert_multi_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_code == FC_MULTI) |-> ($stable(flt_addr) && $stable(flt_vpn)));
    assert_addr_err_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv) |=> !(rsp_code == FC_ADDR_RD || rsp_code == FC_ADDR_WR));
    assert_no_exec_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && need_search) |=> !rsp_perm[2]);
    assert_port_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && ld_valid));
endmodule

// File: tb/data_xlate_unit_tb_top.sv
module data_xlate_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xlate_en = 1'b0;
    logic [5:0]  cfg_wrap_bound = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_store = 1'b0;
    logic        req_priv = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_entry_ok = 1'b0;
    logic [21:0] ld_vpn = '0;
    logic [18:0] ld_ppn = '0;
    logic [1:0]  ld_size = '0;
    logic [1:0]  ld_prot = '0;
    logic        ld_dirty = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [11:0] rsp_code;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [5:0]  rep_idx;
    logic [31:0] flt_addr;
    logic [21:0] flt_vpn;

    always #(CLK_PERIOD/2) clk = ~clk;

    data_xlate_unit dut_i (.*);

    int n_checks = 0;
    int n_fail = 0;

    // Behavioural model state.
    int          m_ok[64], m_vpn[64], m_ppn[64], m_sz[64], m_prot[64], m_dirty[64];
    int          m_idx = 0;
    logic [31:0] m_faddr = '0;

    task automatic check(string req, string what, longint got, longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic longint pg_bytes(int sz);
        case (sz)
            0: return 64'd1024;
            1: return 64'd4096;
            2: return 64'd65536;
            default: return 64'd1048576;
        endcase
    endfunction

    task automatic do_load(int ok, int vpn, int ppn, int sz, int prot, int dirty);
        ld_valid = 1'b1; ld_entry_ok = ok[0]; ld_vpn = vpn[21:0]; ld_ppn = ppn[18:0];
        ld_size = sz[1:0]; ld_prot = prot[1:0]; ld_dirty = dirty[0];
        m_ok[m_idx] = ok; m_vpn[m_idx] = vpn; m_ppn[m_idx] = ppn;
        m_sz[m_idx] = sz; m_prot[m_idx] = prot; m_dirty[m_idx] = dirty;
        @(negedge clk);
        ld_valid = 1'b0;
        check("R13", "index after load", rep_idx, m_idx);
        check("R1", "idle rsp_valid", rsp_valid, 0);
    endtask

    task automatic do_req(logic [31:0] a, bit st, bit pv, string req);
        longint ua = a;
        int     e_fault = 1, e_code = 0, e_perm = 0, nhit = 0, hi = 0;
        longint e_pa = 0;
        bit     search = 0;
        if ((ua >= 64'h8000_0000 && ua <= 64'hBFFF_FFFF) || ua >= 64'hE000_0000) begin
            if (!pv && !(ua >= 64'hE000_0000 && ua <= 64'hE3FF_FFFF))
                e_code = st ? 'h100 : 'h0E0;
            else begin
                e_fault = 0; e_perm = 7;
                e_pa = (ua < 64'hC000_0000) ? ua % 64'h2000_0000 : ua;
            end
        end else if (!cfg_xlate_en) begin
            e_fault = 0; e_perm = 7; e_pa = ua % 64'h2000_0000;
        end else begin
            search = 1;
            for (int i = 0; i < 64; i++) begin
                longint sz = pg_bytes(m_sz[i]);
                longint base = (longint'(m_vpn[i]) * 1024) / sz * sz;
                if (m_ok[i] != 0 && ua >= base && ua < base + sz) begin nhit++; hi = i; end
            end
            if (nhit > 1) e_code = 'h140;
            else if (nhit == 0) e_code = st ? 'h060 : 'h040;
            else if (!pv && m_prot[hi] < 2) e_code = st ? 'h0C0 : 'h0A0;
            else if (st && m_prot[hi] % 2 == 0) e_code = 'h0C0;
            else if (st && m_dirty[hi] == 0) e_code = 'h080;
            else begin
                longint sz = pg_bytes(m_sz[hi]);
                e_fault = 0;
                e_pa = (longint'(m_ppn[hi]) * 1024) / sz * sz + ua % sz;
                e_perm = 1 + ((m_prot[hi] % 2 == 1 && m_dirty[hi] == 1) ? 2 : 0);
            end
        end
        req_valid = 1'b1; req_addr = a; req_store = st; req_priv = pv;
        @(negedge clk);
        req_valid = 1'b0;
        if (e_fault == 1 && e_code != 'h140) m_faddr = a;
        if (search) begin
            m_idx = m_idx + 1;
            if ((cfg_wrap_bound != 0 && m_idx > cfg_wrap_bound) || m_idx > 63) m_idx = 0;
        end
        check("R1", "rsp_valid", rsp_valid, 1);
        check(req, "fault", rsp_fault, e_fault);
        check(req, "code", rsp_code, e_code);
        check(req, "paddr", rsp_paddr, e_pa);
        check(req, "perm", rsp_perm, e_perm);
        check(e_code == 'h140 ? "R10" : "R11", "flt_addr", flt_addr, m_faddr);
        check("R11", "flt_vpn", flt_vpn, m_faddr[31:10]);
        check("R12", "rep_idx", rep_idx, m_idx);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_ok[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset rsp_valid", rsp_valid, 0);
        check("R12", "reset rep_idx", rep_idx, 0);
        check("R11", "reset flt_addr", flt_addr, 0);

        // Translation off.
        do_req(32'h1234_5678, 0, 1, "R4");
        do_req(32'h7FFF_FFFC, 1, 0, "R4");
        do_req(32'hC123_4560, 0, 0, "R4");
        // Fixed windows.
        do_req(32'h9ABC_DEF0, 0, 1, "R2");
        do_req(32'hFF00_1234, 1, 1, "R2");
        do_req(32'hA000_0000, 0, 0, "R3");
        do_req(32'hF000_0000, 1, 0, "R3");
        do_req(32'hE3FF_FFFC, 1, 0, "R3");
        do_req(32'hE400_0000, 0, 0, "R3");

        cfg_xlate_en = 1'b1;
        do_req(32'h0040_0010, 0, 1, "R6");
        do_req(32'h0040_0010, 1, 1, "R6");
        do_req(32'h8000_0040, 0, 1, "R2");

        do_load(1, 'h1000, 'h12345, 1, 3, 1);
        do_req(32'h0040_0ABC, 0, 1, "R5");
        do_req(32'h0040_0FFC, 1, 0, "R9");
        do_load(1, 'h40000, 'h7FFFF, 3, 3, 1);
        do_req(32'h100A_BCDE, 0, 0, "R5");
        do_load(1, 'h2000, 'h00321, 0, 0, 1);
        do_req(32'h0080_03F0, 0, 0, "R7");
        do_req(32'h0080_0004, 1, 0, "R7");
        do_req(32'h0080_0100, 0, 1, "R9");
        do_req(32'h0080_0100, 1, 1, "R8");
        do_req(32'h0080_0400, 0, 1, "R6");
        do_load(1, 'h3000, 'h01000, 2, 2, 0);
        do_req(32'h00C0_FFF0, 0, 0, "R9");
        do_req(32'h00C0_1000, 1, 0, "R8");
        do_load(1, 'h4000, 'h02002, 1, 3, 0);
        do_req(32'h0100_0800, 1, 1, "R8");
        do_req(32'h0100_0800, 0, 0, "R9");
        do_load(0, 'h8000, 'h00001, 1, 3, 1);
        do_req(32'h0200_0000, 0, 1, "R13");
        do_load(1, 'h1005, 'h05555, 2, 3, 1);
        do_req(32'h0040_0010, 0, 1, "R10");
        do_req(32'h0040_F000, 1, 1, "R10");

        // Programmable wrap.
        cfg_wrap_bound = 6'd5;
        for (int i = 0; i < 8; i++) do_req(32'h0300_0000, 0, 1, "R12");
        cfg_wrap_bound = 6'd0;
        for (int i = 0; i < 70; i++) do_req(32'h0300_0400, 1, 1, "R12");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule